// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps wall-clock time and date in packed BCD. A one-cycle strobe at 128 Hz advances a binary sub-second counter; each time that counter wraps, the seconds field steps and the carry runs through minutes, hours, weekday, day of month, month and a four-digit year (century byte plus year-within-century byte). Month lengths and leap years, including the 400-year century rule, are handled in hardware.

Software reaches every field through a small indexed register port with combinational read data. To set the time it stops the counters and clears the prescaler, writes the fields, then restarts. A sticky carry flag marks that a seconds step happened, so a reader can clear it, read all fields, and retry when it finds the flag set again; the flag can also raise an interrupt. A one-shot half-minute adjust rounds the seconds to the nearest minute.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset: sub-second 0, time 00:00:00, weekday 6, day 0x01, month 0x01, year 0x2000, both control registers 0, irq_o low.
- R2: Register index 0 reads the sub-second counter, a SUBSEC_W-bit binary count of tick_i strobes while running; each wrap from all-ones to 0 steps seconds by one.
- R3: Seconds and minutes roll 0x59 to 0x00 with carry, hours 0x23 to 0x00 with carry, month 0x12 to 0x01 with carry into the year; year low byte 0x99 rolls to 0x00 and steps the century byte, which itself wraps 0x99 to 0x00.
- R4: Day of month rolls to 0x01 after 0x31, 0x30 (months 4, 6, 9, 11), 0x28, or 0x29 for February of a leap year: a year whose low byte is a multiple of 4, or, when the low byte is 0x00, whose century is a multiple of 4.
- R5: Weekday (index 4) steps together with the day of month and wraps 6 to 0.
- R6: Indices 1 to 7 hold seconds, minutes, hours, weekday, day, month, year (16 bits); writes to them take effect only while the start bit is 0 and are ignored while it is 1. Indices 8 to 13 read 0.
- R7: Counting (sub-second and time) happens only when start (control 2 bit 0) and enable (control 2 bit 3) are both 1.
- R8: While prescaler clear (control 2 bit 1) is 1 the sub-second counter reads 0 and does not count.
- R9: Carry flag (control 1, index 14, bit 7) is set by every seconds step; writing 0 to bit 7 clears it, writing 1 leaves it unchanged; a step in the same cycle as a clearing write wins.
- R10: irq_o is high exactly when the carry flag and carry interrupt enable (control 1 bit 4) are both 1.
- R11: Writing 1 to control 2 bit 2 sets the adjust bit; on the next cycle seconds become 0x00, one minute is carried if seconds were 0x30 or more, and the bit reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 128 Hz strobe, one clock wide |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Carry interrupt |

## Verification
A tick seen at a clock edge moves the sub-second counter, and on a wrap the whole time and date and the carry flag, at that same edge; a write lands at the edge it is presented on; an adjust lands one edge after the control write. The bench drives inputs and samples after the falling edge, counts exactly the rising edges that carry a tick, waits one extra edge after an adjust request, and reads back through the combinational read port only once nothing is pending. Expected times come from a binary calendar model in the bench converted to BCD.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [3:0] {
    REG_SUBSEC = 4'd0,
    REG_SEC    = 4'd1,
    REG_MIN    = 4'd2,
    REG_HOUR   = 4'd3,
    REG_WDAY   = 4'd4,
    REG_DAY    = 4'd5,
    REG_MON    = 4'd6,
    REG_YEAR   = 4'd7,
    REG_CTL1   = 4'd14,
    REG_CTL2   = 4'd15
  } reg_idx_e;

  typedef struct packed {
    logic [15:0] yr;
    logic [7:0]  mon;
    logic [7:0]  day;
    logic [7:0]  wday;
    logic [7:0]  hr;
    logic [7:0]  min;
    logic [7:0]  sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // packed BCD byte divisible by 4
  function automatic logic bcd_div4(input logic [7:0] v);
    if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
    return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
  endfunction

  function automatic logic is_leap(input logic [15:0] y);
    if (y[7:0] == 8'h00) return bcd_div4(y[15:8]);
    return bcd_div4(y[7:0]);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = run_i && tick_i && !clr_i && (cnt_q == CNT_MAX);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sec_inc_i,
  input  logic      adj_i,
  input  logic      wr_i,
  input  reg_idx_e  wr_idx_i,
  input  logic [15:0] wr_data_i,
  output rtc_time_t time_o
);
  localparam rtc_time_t TIME_RST = '{yr: 16'h2000, mon: 8'h01, day: 8'h01,
                                     wday: 8'h06, hr: 8'h00, min: 8'h00, sec: 8'h00};

  rtc_time_t cur_q, nxt;
  logic c_min, c_hr, c_day, c_mon, c_yr, leap;

  assign leap = is_leap(cur_q.yr);

  always_comb begin
    nxt   = cur_q;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    // adjust has priority over a same-cycle seconds step
    if (adj_i) begin
      nxt.sec = 8'h00;
      c_min   = (cur_q.sec >= 8'h30);
    end else if (sec_inc_i) begin
      if (cur_q.sec >= 8'h59) begin nxt.sec = 8'h00; c_min = 1'b1; end
      else nxt.sec = bcd_inc(cur_q.sec);
    end
    if (c_min) begin
      if (cur_q.min >= 8'h59) begin nxt.min = 8'h00; c_hr = 1'b1; end
      else nxt.min = bcd_inc(cur_q.min);
    end
    if (c_hr) begin
      if (cur_q.hr >= 8'h23) begin nxt.hr = 8'h00; c_day = 1'b1; end
      else nxt.hr = bcd_inc(cur_q.hr);
    end
    if (c_day) begin
      nxt.wday = (cur_q.wday >= 8'h06) ? 8'h00 : bcd_inc(cur_q.wday);
      if (cur_q.day >= month_len(cur_q.mon, leap)) begin nxt.day = 8'h01; c_mon = 1'b1; end
      else nxt.day = bcd_inc(cur_q.day);
    end
    if (c_mon) begin
      if (cur_q.mon >= 8'h12) begin nxt.mon = 8'h01; c_yr = 1'b1; end
      else nxt.mon = bcd_inc(cur_q.mon);
    end
    if (c_yr) begin
      if (cur_q.yr[7:0] >= 8'h99) begin
        nxt.yr[7:0]  = 8'h00;
        nxt.yr[15:8] = (cur_q.yr[15:8] >= 8'h99) ? 8'h00 : bcd_inc(cur_q.yr[15:8]);
      end else begin
        nxt.yr[7:0] = bcd_inc(cur_q.yr[7:0]);
      end
    end
    if (wr_i && !adj_i) begin
      case (wr_idx_i)
        REG_SEC:  nxt.sec  = wr_data_i[7:0];
        REG_MIN:  nxt.min  = wr_data_i[7:0];
        REG_HOUR: nxt.hr   = wr_data_i[7:0];
        REG_WDAY: nxt.wday = wr_data_i[7:0];
        REG_DAY:  nxt.day  = wr_data_i[7:0];
        REG_MON:  nxt.mon  = wr_data_i[7:0];
        REG_YEAR: nxt.yr   = wr_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= TIME_RST;
    else         cur_q <= nxt;
  end

  assign time_o = cur_q;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int SUBSEC_W = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_i,
  input  logic [3:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o
);
  localparam int PAD_W = 16 - SUBSEC_W;

  reg_idx_e      idx;
  logic          start_q, en_q, prst_q, adj_q, cf_q, cie_q;
  logic          running, sec_inc, wr_ctl1, wr_ctl2, wr_time;
  logic [SUBSEC_W-1:0] sub_cnt;
  rtc_time_t     cur_time;

  assign idx     = reg_idx_e'(addr_i);
  assign running = start_q && en_q;
  assign wr_ctl1 = wr_i && (idx == REG_CTL1);
  assign wr_ctl2 = wr_i && (idx == REG_CTL2);
  assign wr_time = wr_i && !start_q;

  rtc_prescaler #(.W(SUBSEC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (prst_q),
    .run_i  (running),
    .tick_i (tick_i),
    .cnt_o  (sub_cnt),
    .wrap_o (sec_inc)
  );

  rtc_calendar u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_inc_i (sec_inc),
    .adj_i     (adj_q),
    .wr_i      (wr_time),
    .wr_idx_i  (idx),
    .wr_data_i (wdata_i),
    .time_o    (cur_time)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      en_q    <= 1'b0;
      prst_q  <= 1'b0;
      adj_q   <= 1'b0;
      cf_q    <= 1'b0;
      cie_q   <= 1'b0;
    end else begin
      // a seconds step beats a clearing write
      cf_q <= sec_inc || (cf_q && !(wr_ctl1 && !wdata_i[7]));
      if (wr_ctl1) cie_q <= wdata_i[4];
      adj_q <= wr_ctl2 && wdata_i[2];
      if (wr_ctl2) begin
        start_q <= wdata_i[0];
        prst_q  <= wdata_i[1];
        en_q    <= wdata_i[3];
      end
    end
  end

  always_comb begin
    case (idx)
      REG_SUBSEC: rdata_o = {{PAD_W{1'b0}}, sub_cnt};
      REG_SEC:    rdata_o = {8'h00, cur_time.sec};
      REG_MIN:    rdata_o = {8'h00, cur_time.min};
      REG_HOUR:   rdata_o = {8'h00, cur_time.hr};
      REG_WDAY:   rdata_o = {8'h00, cur_time.wday};
      REG_DAY:    rdata_o = {8'h00, cur_time.day};
      REG_MON:    rdata_o = {8'h00, cur_time.mon};
      REG_YEAR:   rdata_o = cur_time.yr;
      REG_CTL1:   rdata_o = {8'h00, cf_q, 2'b00, cie_q, 4'h0};
      REG_CTL2:   rdata_o = {12'h000, en_q, adj_q, prst_q, start_q};
      default:    rdata_o = 16'h0000;
    endcase
  end

  assign irq_o = cf_q && cie_q;
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk
  import rtc_pkg::*;
#(
  parameter int SUBSEC_W = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_i,
  input logic [3:0]          addr_i,
  input logic                irq_o,
  input logic                cf_q,
  input logic                cie_q,
  input logic                adj_q,
  input logic                prst_q,
  input logic                start_q,
  input logic                en_q,
  input logic                sec_inc,
  input logic [SUBSEC_W-1:0] sub_cnt,
  input rtc_time_t           cur_time
);
  // R8
  presc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_q |=> (sub_cnt == '0));

  // R9
  carry_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_inc |=> cf_q);

  // R11
  adjust_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_q && !(wr_i && addr_i == 4'd15)) |=> (cur_time.sec == 8'h00) && !adj_q);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(start_q && en_q) && !adj_q && !wr_i && !prst_q) |=> ($stable(cur_time) && $stable(sub_cnt)));

  // R6
  wr_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && wr_i && addr_i >= 4'd1 && addr_i <= 4'd7 && !sec_inc && !adj_q) |=> $stable(cur_time));

  // R10
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cf_q) && cie_q) |-> irq_o);

  // R10
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cie_q |-> !irq_o);
endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.SUBSEC_W(SUBSEC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .irq_o    (irq_o),
  .cf_q     (cf_q),
  .cie_q    (cie_q),
  .adj_q    (adj_q),
  .prst_q   (prst_q),
  .start_q  (start_q),
  .en_q     (en_q),
  .sec_inc  (sec_inc),
  .sub_cnt  (sub_cnt),
  .cur_time (cur_time)
);

// File: tb/bcd_rtc_core_test.sv
`timescale 1ns/1ps
module bcd_rtc_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = 4'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  int ms, mmi, mh, mw, md, mmo, my;

  always #2 clk_i = ~clk_i;

  bcd_rtc_core uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] bcd8(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [15:0] bcdy(int y);
    return {bcd8(y / 100), bcd8(y % 100)};
  endfunction

  function automatic int dim(int y, int m);
    bit lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_sec();
    ms++;
    if (ms == 60) begin
      ms = 0; mmi++;
      if (mmi == 60) begin
        mmi = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw + 1) % 7; md++;
          if (md > dim(my, mmo)) begin
            md = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 10000; end
          end
        end
      end
    end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(int idx, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = 4'(idx);
    #1 d = rdata_o;
  endtask

  task automatic wr(int idx, logic [15:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 4'(idx); wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic set_time(int y, int mo, int d, int w, int h, int mi, int s);
    wr(15, 16'h0002);
    wr(1, {8'h0, bcd8(s)});  wr(2, {8'h0, bcd8(mi)}); wr(3, {8'h0, bcd8(h)});
    wr(4, {8'h0, bcd8(w)});  wr(5, {8'h0, bcd8(d)});  wr(6, {8'h0, bcd8(mo)});
    wr(7, bcdy(y));
    wr(15, 16'h0009);
    my = y; mmo = mo; md = d; mw = w; mh = h; mmi = mi; ms = s;
  endtask

  task automatic cmp_time(string req);
    logic [15:0] d;
    rd(1, d); chk({req, " sec"},  d, {8'h0, bcd8(ms)});
    rd(2, d); chk({req, " min"},  d, {8'h0, bcd8(mmi)});
    rd(3, d); chk({req, " hour"}, d, {8'h0, bcd8(mh)});
    rd(4, d); chk({req, " wday"}, d, {8'h0, bcd8(mw)});
    rd(5, d); chk({req, " day"},  d, {8'h0, bcd8(md)});
    rd(6, d); chk({req, " mon"},  d, {8'h0, bcd8(mmo)});
    rd(7, d); chk({req, " year"}, d, bcdy(my));
  endtask

  task automatic run_secs(int n);
    ticks(n * 128);
    for (int i = 0; i < n; i++) model_sec();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    my = 2000; mmo = 1; md = 1; mw = 6; mh = 0; mmi = 0; ms = 0;
    rd(0, d);  chk("R1 subsec", d, 16'h0);
    cmp_time("R1");
    rd(14, d); chk("R1 ctl1", d, 16'h0);
    rd(15, d); chk("R1 ctl2", d, 16'h0);
    chk("R1 irq", {15'h0, irq_o}, 16'h0);

    // R6 unused indices read zero
    wr(9, 16'h00ff);
    rd(9, d);  chk("R6 unused idx", d, 16'h0);

    // R2 sub-second count and wrap
    set_time(2023, 6, 15, 4, 10, 20, 30);
    ticks(50);
    rd(0, d);  chk("R2 subsec 50", d, 16'd50);
    rd(1, d);  chk("R2 sec held", d, 16'h0030);
    ticks(78); model_sec();
    rd(0, d);  chk("R2 subsec wrap", d, 16'd0);
    cmp_time("R2");

    // R6 write ignored while started
    wr(1, 16'h0011);
    rd(1, d);  chk("R6 sec write ignored", d, {8'h0, bcd8(ms)});

    // R8 prescaler clear
    ticks(40);
    wr(15, 16'h000b);
    rd(0, d);  chk("R8 cleared", d, 16'd0);
    ticks(20);
    rd(0, d);  chk("R8 held", d, 16'd0);

    // R7 start without enable, enable without start
    wr(15, 16'h0001);
    ticks(300);
    rd(0, d);  chk("R7 no enable subsec", d, 16'd0);
    cmp_time("R7 no enable");
    wr(15, 16'h0008);
    ticks(300);
    cmp_time("R7 no start");

    // R3 full cascade with century
    set_time(2099, 12, 31, 3, 23, 59, 59);
    run_secs(1);
    cmp_time("R3 century");
    set_time(9999, 12, 31, 2, 23, 59, 59);
    run_secs(1);
    cmp_time("R3 century wrap");

    // R4 leap rules, R5 weekday wrap
    set_time(2023, 2, 28, 6, 23, 59, 59); run_secs(1); cmp_time("R4 R5 2023");
    set_time(2024, 2, 28, 0, 23, 59, 59); run_secs(1); cmp_time("R4 2024");
    set_time(2100, 2, 28, 1, 23, 59, 59); run_secs(1); cmp_time("R4 2100");
    set_time(2000, 2, 28, 1, 23, 59, 59); run_secs(1); cmp_time("R4 2000");
    set_time(2024, 4, 30, 2, 23, 59, 59); run_secs(1); cmp_time("R4 april");

    // R9 R10 carry flag and interrupt
    wr(14, 16'h0000);
    rd(14, d); chk("R9 cleared", d, 16'h0000);
    run_secs(1);
    rd(14, d); chk("R9 set", d, 16'h0080);
    chk("R10 masked", {15'h0, irq_o}, 16'h0);
    wr(14, 16'h0090);
    rd(14, d); chk("R9 write1 keeps", d, 16'h0090);
    chk("R10 irq on", {15'h0, irq_o}, 16'h1);
    wr(14, 16'h0010);
    rd(14, d); chk("R9 write0 clears", d, 16'h0010);
    chk("R10 irq off", {15'h0, irq_o}, 16'h0);
    wr(14, 16'h0000);

    // R11 half-minute adjust
    set_time(2024, 1, 31, 3, 23, 59, 45);
    wr(15, 16'h000d);
    ms = 59; model_sec();
    cmp_time("R11 round up");
    rd(15, d); chk("R11 self clear", d, 16'h0009);
    set_time(2024, 5, 5, 0, 8, 10, 20);
    wr(15, 16'h000d);
    ms = 0;
    cmp_time("R11 round down");

    // R3 R4 R5 random dates near rollovers
    for (int k = 0; k < 16; k++) begin
      int y, mo, dd, h, mi, s, n;
      y  = 1999 + int'($urandom % 404);
      mo = 1 + int'($urandom % 12);
      dd = ($urandom % 2) ? dim(y, mo) : 1 + int'($urandom % dim(y, mo));
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      mi = ($urandom % 2) ? 59 : int'($urandom % 60);
      s  = ($urandom % 2) ? 57 + int'($urandom % 3) : int'($urandom % 60);
      n  = 1 + int'($urandom % 3);
      set_time(y, mo, dd, int'($urandom % 7), h, mi, s);
      run_secs(n);
      cmp_time("R3 R4 R5 random");
    end

    summary();
  end
endmodule